// File: doc/BRIEF.md
# SerDes Indirect Register Access Bridge

The bridge gives a host register bus a way into SerDes configuration registers that have no place in the host address map. The host sees a small window of three registers: a command register, an address register and a data register. The host stages a SerDes register address, and for a store also a data word. A single write to the command register then starts the transfer. That one write sets the start flag, the direction and the target instance together.

Transfers leave on an internal request/acknowledge handshake toward one of up to eight SerDes instances. The host does not poll for completion. It waits a short fixed time before its next access, so every transfer must end within a bounded number of cycles. An instance that is not fitted completes at once. An instance that never answers is cut off by a timeout. In both cases a load returns all ones.

Top module: `sds_ind_bridge`

## Requirements
- R1: After reset the command, address and data registers all read zero, and `sds_req_o` is low.
- R2: The host window is decoded by offset: 0 is command, 1 is address, 2 is data, and 3 reads zero. The command register reads back with bit 7 = busy, bit 6 = direction (1 store, 0 load), bit 5 = overrun, and bits 2:0 = instance index. All other bits read zero.
- R3: A command write with bit 7 set while idle sets busy in the next cycle. From that cycle `sds_req_o` is high, with `sds_sel_o` = bits 2:0, `sds_we_o` = bit 6, and the staged address and data on `sds_addr_o` and `sds_wdata_o`.
- R4: The request stays high until the cycle in which `sds_ack_i` is high. It drops, and busy clears, in the following cycle. A store is carried out by the target on that acknowledge.
- R5: On a load, `sds_rdata_i` is captured into the data register in the acknowledge cycle. The value reads back from the next cycle on.
- R6: A command write with bit 7 clear while idle updates the direction and index only. It starts no request.
- R7: A command write while busy is ignored: index, direction and the running transfer are unchanged. It sets the sticky overrun bit. An accepted command write with bit 5 set clears overrun.
- R8: Host writes to the address and data registers while busy are ignored. During a load, only the response can change the data register.
- R9: An index of `NUM_SDS` or above raises no request and keeps busy high for exactly one cycle. A load then returns all ones, and a store is dropped.
- R10: If no acknowledge arrives within `TIMEOUT_CYC` request cycles, the transfer is abandoned. Busy clears, the request drops, and a load returns all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| hst_wr_i | input | 1 | Host write strobe, one cycle per write |
| hst_addr_i | input | 2 | Host register offset |
| hst_wdata_i | input | DATA_W | Host write data |
| hst_rdata_o | output | DATA_W | Read data of the register at `hst_addr_i` (combinational) |
| sds_req_o | output | 1 | Request to the SerDes target, held until acknowledged |
| sds_we_o | output | 1 | Request direction, 1 = store |
| sds_sel_o | output | 3 | Target instance index |
| sds_addr_o | output | SDS_AW | SerDes register address |
| sds_wdata_o | output | DATA_W | SerDes store data |
| sds_ack_i | input | 1 | One-cycle acknowledge from the target |
| sds_rdata_i | input | DATA_W | Load data, valid with `sds_ack_i` |

## Verification
A wrong busy flag appears at once in bit 7 of the command readback. It also shows up in `sds_req_o` in the same cycle, and then as command writes that are wrongly accepted or wrongly flagged as overrun. A bad staged address, data word, index or direction is visible on the request outputs in the first request cycle. A wrong capture rule appears in the data register one cycle after the acknowledge, or after the absent-target or timeout completion. The bench compares every output with a behavioural model on every clock, so each of these faults is caught within one cycle of its first effect.

// File: rtl/sds_bridge_pkg.sv
package sds_bridge_pkg;
  localparam int unsigned HOST_AW = 2;
  localparam int unsigned IDX_W   = 3;

  localparam logic [HOST_AW-1:0] OFS_CMD  = 2'd0;
  localparam logic [HOST_AW-1:0] OFS_ADDR = 2'd1;
  localparam logic [HOST_AW-1:0] OFS_DATA = 2'd2;

  localparam int unsigned CMD_RUN_BIT = 7;
  localparam int unsigned CMD_WR_BIT  = 6;
  localparam int unsigned CMD_OVR_BIT = 5;
endpackage

// File: rtl/sds_host_regs.sv
module sds_host_regs
  import sds_bridge_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned SDS_AW = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               hst_wr_i,
  input  logic [HOST_AW-1:0] hst_addr_i,
  input  logic [DATA_W-1:0]  hst_wdata_i,
  output logic [DATA_W-1:0]  hst_rdata_o,
  input  logic               busy_i,
  input  logic               rsp_vld_i,
  input  logic [DATA_W-1:0]  rsp_data_i,
  output logic               launch_o,
  output logic               cmd_wr_o,
  output logic [IDX_W-1:0]   cmd_idx_o,
  output logic [SDS_AW-1:0]  stg_addr_o,
  output logic [DATA_W-1:0]  stg_data_o
);
  logic              wr_q, ovr_q;
  logic [IDX_W-1:0]  idx_q;
  logic [SDS_AW-1:0] addr_q;
  logic [DATA_W-1:0] data_q;
  logic              cmd_we, cmd_acc;

  assign cmd_we   = hst_wr_i && (hst_addr_i == OFS_CMD);
  assign cmd_acc  = cmd_we && !busy_i;
  assign launch_o = cmd_acc && hst_wdata_i[CMD_RUN_BIT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= 1'b0;
      idx_q <= '0;
      ovr_q <= 1'b0;
    end else if (cmd_we && busy_i) begin
      ovr_q <= 1'b1;
    end else if (cmd_acc) begin
      wr_q  <= hst_wdata_i[CMD_WR_BIT];
      idx_q <= hst_wdata_i[IDX_W-1:0];
      if (hst_wdata_i[CMD_OVR_BIT]) ovr_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
    end else if (hst_wr_i && (hst_addr_i == OFS_ADDR) && !busy_i) begin
      addr_q <= hst_wdata_i[SDS_AW-1:0];
    end
  end

  // response capture outranks host writes
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
    end else if (rsp_vld_i) begin
      data_q <= rsp_data_i;
    end else if (hst_wr_i && (hst_addr_i == OFS_DATA) && !busy_i) begin
      data_q <= hst_wdata_i;
    end
  end

  always_comb begin
    hst_rdata_o = '0;
    unique case (hst_addr_i)
      OFS_CMD: begin
        hst_rdata_o[CMD_RUN_BIT] = busy_i;
        hst_rdata_o[CMD_WR_BIT]  = wr_q;
        hst_rdata_o[CMD_OVR_BIT] = ovr_q;
        hst_rdata_o[IDX_W-1:0]   = idx_q;
      end
      OFS_ADDR: hst_rdata_o[SDS_AW-1:0] = addr_q;
      OFS_DATA: hst_rdata_o = data_q;
      default:  hst_rdata_o = '0;
    endcase
  end

  assign cmd_wr_o   = wr_q;
  assign cmd_idx_o  = idx_q;
  assign stg_addr_o = addr_q;
  assign stg_data_o = data_q;

  AST_OVR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovr_q && !(cmd_acc && hst_wdata_i[CMD_OVR_BIT]) |=> ovr_q); // R7
  AST_BUSY_CMD_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |=> $stable(idx_q) && $stable(wr_q)); // R7
  AST_BUSY_ADDR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |=> $stable(addr_q)); // R8
  AST_BUSY_DATA_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i && !rsp_vld_i |=> $stable(data_q)); // R8
endmodule

// File: rtl/sds_xfer_ctrl.sv
module sds_xfer_ctrl
  import sds_bridge_pkg::*;
#(
  parameter int unsigned DATA_W      = 16,
  parameter int unsigned NUM_SDS     = 6,
  parameter int unsigned TIMEOUT_CYC = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              launch_i,
  input  logic              wr_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic              sds_ack_i,
  input  logic [DATA_W-1:0] sds_rdata_i,
  output logic              busy_o,
  output logic              sds_req_o,
  output logic              rsp_vld_o,
  output logic [DATA_W-1:0] rsp_data_o
);
  localparam int unsigned CNT_W   = $clog2(TIMEOUT_CYC + 1);
  localparam int unsigned MAX_IDX = (1 << IDX_W);

  logic             busy_q, present, timeout, done;
  logic [CNT_W-1:0] cnt_q;

  generate
    if (NUM_SDS >= MAX_IDX) begin : g_all_present
      assign present = 1'b1;
    end else begin : g_partial
      assign present = (32'(idx_i) < NUM_SDS);
    end
  endgenerate

  assign timeout = busy_q && present && !sds_ack_i &&
                   (cnt_q == CNT_W'(TIMEOUT_CYC - 1));
  assign done    = busy_q && (!present || sds_ack_i || timeout);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (launch_i) begin
      busy_q <= 1'b1;
      cnt_q  <= '0;
    end else if (done) begin
      busy_q <= 1'b0;
    end else if (busy_q) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign busy_o     = busy_q;
  assign sds_req_o  = busy_q && present;
  assign rsp_vld_o  = done && !wr_i;
  assign rsp_data_o = (present && sds_ack_i) ? sds_rdata_i : '1;

  AST_LAUNCH_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    launch_i |-> !busy_q); // R7
  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sds_req_o && !sds_ack_i && !timeout |=> sds_req_o); // R4
  AST_ACK_DROPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sds_req_o && sds_ack_i |=> !busy_o && !sds_req_o); // R4
  AST_ABSENT_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && !present |=> !busy_o); // R9
  AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < CNT_W'(TIMEOUT_CYC)); // R10
endmodule

// File: rtl/sds_ind_bridge.sv
module sds_ind_bridge
  import sds_bridge_pkg::*;
#(
  parameter int unsigned DATA_W      = 16,
  parameter int unsigned SDS_AW      = 16,
  parameter int unsigned NUM_SDS     = 6,
  parameter int unsigned TIMEOUT_CYC = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hst_wr_i,
  input  logic [1:0]        hst_addr_i,
  input  logic [DATA_W-1:0] hst_wdata_i,
  output logic [DATA_W-1:0] hst_rdata_o,
  output logic              sds_req_o,
  output logic              sds_we_o,
  output logic [2:0]        sds_sel_o,
  output logic [SDS_AW-1:0] sds_addr_o,
  output logic [DATA_W-1:0] sds_wdata_o,
  input  logic              sds_ack_i,
  input  logic [DATA_W-1:0] sds_rdata_i
);
  logic              busy, launch, rsp_vld, cmd_wr;
  logic [IDX_W-1:0]  cmd_idx;
  logic [DATA_W-1:0] rsp_data;

  sds_host_regs #(.DATA_W(DATA_W), .SDS_AW(SDS_AW)) u_regs (
    .clk_i, .rst_ni, .hst_wr_i, .hst_addr_i, .hst_wdata_i, .hst_rdata_o,
    .busy_i(busy), .rsp_vld_i(rsp_vld), .rsp_data_i(rsp_data),
    .launch_o(launch), .cmd_wr_o(cmd_wr), .cmd_idx_o(cmd_idx),
    .stg_addr_o(sds_addr_o), .stg_data_o(sds_wdata_o)
  );

  sds_xfer_ctrl #(.DATA_W(DATA_W), .NUM_SDS(NUM_SDS), .TIMEOUT_CYC(TIMEOUT_CYC)) u_ctrl (
    .clk_i, .rst_ni, .launch_i(launch), .wr_i(cmd_wr), .idx_i(cmd_idx),
    .sds_ack_i, .sds_rdata_i, .busy_o(busy), .sds_req_o,
    .rsp_vld_o(rsp_vld), .rsp_data_o(rsp_data)
  );

  assign sds_we_o  = cmd_wr;
  assign sds_sel_o = cmd_idx;

  AST_REQ_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sds_req_o && !sds_ack_i |=> !sds_req_o || ($stable(sds_addr_o) &&
    $stable(sds_sel_o) && $stable(sds_we_o) && $stable(sds_wdata_o))); // R3
  AST_IDLE_NO_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hst_rdata_o[7] && hst_addr_i == OFS_CMD |-> !sds_req_o); // R6
endmodule

// File: tb/sim_sds_ind_bridge.sv
module sim_sds_ind_bridge;
  localparam int DATA_W = 16, SDS_AW = 16, NUM_SDS = 6, TIMEOUT_CYC = 64;
  localparam int HALF = 10; // 50 MHz, 20 ns period

  logic clk = 1'b0, rst_n = 1'b0;
  logic hst_wr = 1'b0;
  logic [1:0] hst_addr = 2'd0;
  logic [15:0] hst_wdata = '0, hst_rdata;
  logic sds_req, sds_we, sds_ack = 1'b0;
  logic [2:0] sds_sel;
  logic [15:0] sds_addr, sds_wdata, sds_rdata = '0;

  always #HALF clk = ~clk;

  sds_ind_bridge #(.DATA_W(DATA_W), .SDS_AW(SDS_AW), .NUM_SDS(NUM_SDS),
                   .TIMEOUT_CYC(TIMEOUT_CYC)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .hst_wr_i(hst_wr), .hst_addr_i(hst_addr),
    .hst_wdata_i(hst_wdata), .hst_rdata_o(hst_rdata), .sds_req_o(sds_req),
    .sds_we_o(sds_we), .sds_sel_o(sds_sel), .sds_addr_o(sds_addr),
    .sds_wdata_o(sds_wdata), .sds_ack_i(sds_ack), .sds_rdata_i(sds_rdata)
  );

  int n_chk = 0, n_err = 0, cyc = 0;
  string cur_req = "R1";

  // target model: register files, ack after rsp_dly request cycles
  logic [15:0] mem [8][16];
  int rsp_dly = 0, wcnt = 0;
  bit stall = 0;

  always @(negedge clk) begin
    if (sds_req && !stall) begin
      if (wcnt == rsp_dly) begin
        sds_ack <= 1'b1;
        if (sds_we) mem[sds_sel][sds_addr[3:0]] = sds_wdata;
        else sds_rdata <= mem[sds_sel][sds_addr[3:0]];
        wcnt = 0;
      end else begin
        sds_ack <= 1'b0;
        wcnt++;
      end
    end else begin
      sds_ack <= 1'b0;
      wcnt = 0;
    end
  end

  // behavioural reference model
  bit m_busy, m_dir, m_ovr;
  int m_idx, m_cnt;
  logic [15:0] m_addr, m_data;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy = 0; m_dir = 0; m_ovr = 0; m_idx = 0; m_cnt = 0;
      m_addr = '0; m_data = '0;
    end else begin
      bit was_busy;
      was_busy = m_busy;
      if (m_busy) begin
        if (m_idx >= NUM_SDS) begin
          m_busy = 0;
          if (!m_dir) m_data = 16'hFFFF;
        end else if (sds_ack) begin
          m_busy = 0;
          if (!m_dir) m_data = sds_rdata;
        end else if (m_cnt == TIMEOUT_CYC - 1) begin
          m_busy = 0;
          if (!m_dir) m_data = 16'hFFFF;
        end else m_cnt++;
      end
      if (hst_wr) begin
        case (hst_addr)
          2'd0: if (was_busy) m_ovr = 1;
                else begin
                  m_dir = hst_wdata[6];
                  m_idx = int'(hst_wdata[2:0]);
                  if (hst_wdata[5]) m_ovr = 0;
                  if (hst_wdata[7]) begin m_busy = 1; m_cnt = 0; end
                end
          2'd1: if (!was_busy) m_addr = hst_wdata;
          2'd2: if (!was_busy) m_data = hst_wdata;
          default: ;
        endcase
      end
    end
  end

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%h exp=%h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  function automatic logic [15:0] exp_rd(logic [1:0] a);
    case (a)
      2'd0: return {8'd0, m_busy, m_dir, m_ovr, 2'b00, 3'(m_idx)};
      2'd1: return m_addr;
      2'd2: return m_data;
      default: return 16'h0;
    endcase
  endfunction

  // per-cycle comparison, away from the clock edge
  always @(negedge clk) begin
    #5;
    if (rst_n) begin
      bit req_exp;
      req_exp = m_busy && (m_idx < NUM_SDS);
      chk({cur_req, " rdata"}, hst_rdata, exp_rd(hst_addr));
      chk({cur_req, " req"}, 16'(sds_req), 16'(req_exp));
      if (req_exp) begin
        chk({cur_req, " sel"}, 16'(sds_sel), 16'(m_idx));
        chk({cur_req, " we"}, 16'(sds_we), 16'(m_dir));
        chk({cur_req, " addr"}, sds_addr, m_addr);
        chk({cur_req, " wdata"}, sds_wdata, m_data);
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      n_err++;
      $display("FAIL watchdog act=%0d exp<=50000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  task automatic hwr(logic [1:0] a, logic [15:0] d);
    @(negedge clk);
    hst_wr = 1; hst_addr = a; hst_wdata = d;
    @(negedge clk);
    hst_wr = 0;
  endtask

  task automatic rd_chk(string tag, logic [1:0] a, logic [15:0] e);
    @(negedge clk);
    hst_addr = a;
    #3;
    chk(tag, hst_rdata, e);
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 200 && m_busy; i++) @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < 8; i++)
      for (int j = 0; j < 16; j++) mem[i][j] = 16'(i * 256 + j * 17 + 3);
    repeat (3) @(negedge clk);
    cur_req = "R1";
    rd_chk("R1 cmd", 2'd0, 16'h0);
    rd_chk("R1 addr", 2'd1, 16'h0);
    chk("R1 req", 16'(sds_req), 16'h0);
    rst_n = 1;
    rd_chk("R1 data", 2'd2, 16'h0);
    rd_chk("R2 unused", 2'd3, 16'h0);

    // store to instance 3
    cur_req = "R3";
    rsp_dly = 2;
    hwr(2'd2, 16'hA5A5);
    hwr(2'd1, 16'h0005);
    hwr(2'd0, 16'h00C3);
    chk("R3 busy", 16'(sds_req), 16'h1);
    cur_req = "R4";
    wait_idle();
    chk("R4 stored", mem[3][5], 16'hA5A5);
    rd_chk("R2 cmd fmt", 2'd0, 16'h0043);

    // load with blocked host writes during busy
    cur_req = "R5";
    rsp_dly = 6;
    hwr(2'd2, 16'h0000);
    hwr(2'd0, 16'h0083);
    cur_req = "R8";
    hwr(2'd2, 16'h1111);
    hwr(2'd1, 16'h0009);
    cur_req = "R7";
    hwr(2'd0, 16'h00C1);
    wait_idle();
    rd_chk("R5 load", 2'd2, 16'hA5A5);
    rd_chk("R8 addr kept", 2'd1, 16'h0005);
    rd_chk("R7 ovr set", 2'd0, 16'h0023);

    cur_req = "R6";
    hwr(2'd0, 16'h0025);
    rd_chk("R6 no run", 2'd0, 16'h0005);
    chk("R6 req", 16'(sds_req), 16'h0);

    // absent instance
    cur_req = "R9";
    hwr(2'd1, 16'h0002);
    hwr(2'd0, 16'h0087);
    rd_chk("R9 load ones", 2'd2, 16'hFFFF);
    hwr(2'd2, 16'h7777);
    hwr(2'd0, 16'h00C6);
    rd_chk("R9 idle", 2'd0, 16'h0046);
    chk("R9 no store", mem[6][2], 16'(6 * 256 + 2 * 17 + 3));

    // timeout
    cur_req = "R10";
    stall = 1;
    hwr(2'd0, 16'h0081);
    wait_idle();
    rd_chk("R10 ones", 2'd2, 16'hFFFF);
    rd_chk("R10 idle", 2'd0, 16'h0001);
    stall = 0;

    // mixed traffic across present instances
    cur_req = "R4";
    for (int k = 0; k < NUM_SDS; k++) begin
      rsp_dly = k % 3;
      hwr(2'd1, 16'(k + 4));
      hwr(2'd2, 16'(16'h3000 + k * 16'h0111));
      hwr(2'd0, 16'(16'h00C0 | k));
      wait_idle();
    end
    cur_req = "R5";
    for (int k = 0; k < NUM_SDS; k++) begin
      hwr(2'd1, 16'(k + 4));
      hwr(2'd0, 16'(16'h0080 | k));
      wait_idle();
      rd_chk("R5 readback", 2'd2, 16'(16'h3000 + k * 16'h0111));
    end

    repeat (4) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule